// File: doc/BRIEF.md
# Three-Stage Master Clock Prescaler

This block turns a free-running master clock into the timing strobes that a mono audio converter core needs. Every master clock cycle is one input tick. The ticks pass through three programmable divider stages in series, and the output of the last stage is the internal master clock enable. The first two stages can divide by 1, 2 or 3 and the third by 1, 2 or 4. A frame timer then counts internal master clock pulses. It emits a sample/frame strobe once every 256 pulses, or once every 128 pulses when the short-frame (low group delay) mode is selected. The same counter also produces two modulator enables, one at a quarter and one at half the internal master clock rate.

Everything runs on the single master clock domain and uses one-cycle clock-enable pulses, never derived clocks. The block latches the divider selections and the frame mode only in the cycle of a frame strobe. A frame that is already running therefore always completes with the settings it started with. The control inputs are plain level signals with no handshake. The outputs are single-cycle pulses with no back-pressure, and a consumer must sample them in the cycle they are high.

Top module: `clk_ratio_chain`

## Requirements
- R1: Stage one is selected by `ratio_sel[1:0]` and stage two by `ratio_sel[3:2]`. In each field, 01 divides by 2, 10 divides by 3, and both 00 and 11 pass ticks through unchanged (divide by 1).
- R2: Stage three is selected by `ratio_sel[5:4]`. In this field, 01 divides by 2, 10 divides by 4, and both 00 and 11 pass ticks through unchanged.
- R3: `imclk_en` is a one-cycle pulse that repeats every D master clock cycles, where D is the product of the three active stage ratios. After a frame strobe, the next pulse arrives D cycles later.
- R4: With `short_mode` low, `frame_stb` is high in the same cycle as every 256th `imclk_en` pulse. A frame therefore lasts 256·D cycles.
- R5: With `short_mode` high, `frame_stb` is high in the same cycle as every 128th `imclk_en` pulse. A frame therefore lasts 128·D cycles.
- R6: `dac_mod_en` pulses with every 2nd `imclk_en` pulse and `adc_mod_en` with every 4th. Both are counted from the frame start, so both are high in every cycle where `frame_stb` is high.
- R7: `ratio_sel` and `short_mode` are taken only in a cycle where `frame_stb` is high, and they govern the frame that follows. A change made inside a frame does not alter that frame's length.
- R8: While `rst_n` is low, all four outputs are low. After release, every stage passes ticks through and the frame mode is 256. `imclk_en` is high from the first cycle after release, and the first `frame_stb` coincides with the 256th `imclk_en` pulse.
- R9: With stage one at divide-by-3, stage two at divide-by-2 and stage three at pass-through (`ratio_sel` = 6'b00_01_10), D is 6. A 12.288 MHz master clock then gives a 2.048 MHz internal clock and a frame every 1536 cycles, which is 8 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every cycle is one input tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 6 | Three 2-bit divider selections, stage one in the low bits |
| short_mode | input | 1 | 1 selects 128 internal pulses per frame, 0 selects 256 |
| imclk_en | output | 1 | Internal master clock enable pulse |
| frame_stb | output | 1 | Sample/frame strobe |
| adc_mod_en | output | 1 | Enable at one quarter of the internal clock rate |
| dac_mod_en | output | 1 | Enable at one half of the internal clock rate |

## Verification
Three events can fall in one cycle: the end of a frame, the taking of new settings, and the modulator enables. The bench provokes the first pair by changing `ratio_sel` and `short_mode` in the very cycle of a frame strobe and also a few cycles into a running frame. It judges the result by measuring the current frame's length and the next frame's pulse spacing against the old and new settings. In every frame-strobe cycle it also checks that `imclk_en`, `dac_mod_en` and `adc_mod_en` are all high together.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned MAX_RATIO = 4;
  localparam int unsigned RCNT_W    = $clog2(MAX_RATIO);

  typedef logic [SEL_W-1:0]  ratio_sel_t;
  typedef logic [RCNT_W:0]   ratio_t;

  // Narrow set: 1/2/3. Wide set: 1/2/4. Unused code passes through.
  function automatic ratio_t decode_ratio(ratio_sel_t sel, logic wide);
    case (sel)
      2'b01:   return ratio_t'(2);
      2'b10:   return wide ? ratio_t'(4) : ratio_t'(3);
      default: return ratio_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/ratio_stage.sv
module ratio_stage
  import prescale_pkg::*;
#(
  parameter bit WIDE_SET = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  ratio_sel_t sel_i,
  output logic       en_o
);
  ratio_t            ratio;
  logic [RCNT_W-1:0] last;
  logic [RCNT_W-1:0] cnt;

  assign ratio = decode_ratio(sel_i, WIDE_SET);
  assign last  = RCNT_W'(ratio - 1'b1);
  assign en_o  = en_i && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en_i) begin
      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
  end

  // R3: the phase counter never passes the terminal count of its ratio
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);
endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned SHORT_LEN = 128,
  parameter int unsigned ADC_DIV   = 4,
  parameter int unsigned DAC_DIV   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic short_i,
  output logic frame_o,
  output logic adc_o,
  output logic dac_o
);
  localparam int unsigned FCNT_W = $clog2(FRAME_LEN);
  localparam int unsigned ADC_W  = $clog2(ADC_DIV);
  localparam int unsigned DAC_W  = $clog2(DAC_DIV);

  logic [FCNT_W-1:0] cnt;
  logic [FCNT_W-1:0] last;

  assign last    = short_i ? FCNT_W'(SHORT_LEN - 1) : FCNT_W'(FRAME_LEN - 1);
  assign frame_o = tick_i && (cnt == last);
  assign adc_o   = tick_i && (cnt[ADC_W-1:0] == '1);
  assign dac_o   = tick_i && (cnt[DAC_W-1:0] == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick_i) begin
      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
  end

  // R4: after a frame strobe the next frame starts at phase zero
  assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> (cnt == '0));
  // R6: both modulator enables line up with the frame strobe
  assert_mod_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> (adc_o && dac_o));
  // R6: the slower modulator enable is a subset of the faster one
  assert_adc_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_o |-> dac_o);
endmodule

// File: rtl/clk_ratio_chain.sv
module clk_ratio_chain
  import prescale_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned FRAME_LEN  = 256,
  parameter int unsigned SHORT_LEN  = 128,
  parameter int unsigned ADC_DIV    = 4,
  parameter int unsigned DAC_DIV    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_STAGES*SEL_W-1:0] ratio_sel,
  input  logic                        short_mode,
  output logic                        imclk_en,
  output logic                        frame_stb,
  output logic                        adc_mod_en,
  output logic                        dac_mod_en
);
  localparam int unsigned CFG_W = NUM_STAGES * SEL_W;

  logic [CFG_W-1:0]    act_sel;
  logic                act_short;
  logic [NUM_STAGES:0] en_chain;

  // Settings are taken only at the frame boundary (R7).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel   <= '0;
      act_short <= 1'b0;
    end else if (frame_stb) begin
      act_sel   <= ratio_sel;
      act_short <= short_mode;
    end
  end

  assign en_chain[0] = rst_n;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    ratio_stage #(
      .WIDE_SET (g == NUM_STAGES - 1)
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en_chain[g]),
      .sel_i (act_sel[g*SEL_W +: SEL_W]),
      .en_o  (en_chain[g+1])
    );
  end

  assign imclk_en = en_chain[NUM_STAGES];

  frame_timer #(
    .FRAME_LEN (FRAME_LEN),
    .SHORT_LEN (SHORT_LEN),
    .ADC_DIV   (ADC_DIV),
    .DAC_DIV   (DAC_DIV)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (imclk_en),
    .short_i (act_short),
    .frame_o (frame_stb),
    .adc_o   (adc_mod_en),
    .dac_o   (dac_mod_en)
  );

  // R7: active settings only move in the cycle after a frame strobe
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(act_sel) && $stable(act_short)));
  // R3: a frame strobe never appears without an internal clock pulse
  assert_frame_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> imclk_en);
  // R8: nothing toggles while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R8: assert (!imclk_en && !frame_stb && !adc_mod_en && !dac_mod_en);
    end
  end
endmodule

// File: tb/test_clk_ratio_chain.sv
module test_clk_ratio_chain;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] ratio_sel;
  logic       short_mode;
  logic       imclk_en, frame_stb, adc_mod_en, dac_mod_en;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clk_ratio_chain i_clk_ratio_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_sel  (ratio_sel),
    .short_mode (short_mode),
    .imclk_en   (imclk_en),
    .frame_stb  (frame_stb),
    .adc_mod_en (adc_mod_en),
    .dac_mod_en (dac_mod_en)
  );

  function automatic int narrow_ratio(logic [1:0] s);
    return (s == 2'b01) ? 2 : (s == 2'b10) ? 3 : 1;
  endfunction
  function automatic int wide_ratio(logic [1:0] s);
    return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
  endfunction
  function automatic int total_div(logic [5:0] s);
    return narrow_ratio(s[1:0]) * narrow_ratio(s[3:2]) * wide_ratio(s[5:4]);
  endfunction
  function automatic int frame_pulses(logic sm);
    return sm ? 128 : 256;
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Starts at a negedge where frame_stb is high; measures the next frame.
  task automatic run_frame(string req, int exp_d, int exp_l, int chg_at,
                           logic [5:0] nsel, logic nshort);
    int c = 0, fi = 0, fd = 0, fa = 0, pulses = 0;
    check_eq("R6", "strobes together at frame", {29'd0, imclk_en, adc_mod_en, dac_mod_en}, 7);
    while (c < 20000) begin
      @(negedge clk);
      c++;
      if (imclk_en) begin
        pulses++;
        if (fi == 0) fi = c;
      end
      if (dac_mod_en && fd == 0) fd = c;
      if (adc_mod_en && fa == 0) fa = c;
      if (c == chg_at) begin
        ratio_sel  = nsel;
        short_mode = nshort;
      end
      if (frame_stb) break;
    end
    check_eq("R3", "first imclk_en spacing", fi, exp_d);
    check_eq("R6", "first dac_mod_en spacing", fd, 2 * exp_d);
    check_eq("R6", "first adc_mod_en spacing", fa, 4 * exp_d);
    check_eq(req, "frame length in cycles", c, exp_l * exp_d);
    check_eq(req, "imclk pulses per frame", pulses, exp_l);
  endtask

  // Presents settings in the strobe cycle, so they govern the next frame.
  task automatic apply_frame(string req, logic [5:0] s, logic sm);
    ratio_sel  = s;
    short_mode = sm;
    run_frame(req, total_div(s), frame_pulses(sm), 0, s, sm);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0017));
    rst_n      = 1'b0;
    ratio_sel  = 6'b10_10_10;
    short_mode = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_eq("R8", "outputs during reset",
               {28'd0, imclk_en, frame_stb, adc_mod_en, dac_mod_en}, 0);
    end
    // Inputs held non-default through release: defaults must still rule the first frame.
    rst_n = 1'b1;
    #1;
    check_eq("R8", "imclk_en right after release", int'(imclk_en), 1);
    n = 0;
    while (n < 1000) begin
      if (imclk_en) n++;
      if (frame_stb) break;
      @(negedge clk);
    end
    check_eq("R8", "imclk pulses before first frame", n, 256);
    @(negedge clk);
    while (!frame_stb) @(negedge clk);

    apply_frame("R9", 6'b00_01_10, 1'b0);
    apply_frame("R2", 6'b10_00_00, 1'b0);
    apply_frame("R1", 6'b11_11_11, 1'b0);
    apply_frame("R5", 6'b01_10_10, 1'b1);
    // R7: change a few cycles into a running frame; old settings hold to its end.
    run_frame("R7", 18, 128, 7, 6'b00_00_01, 1'b0);
    run_frame("R7", 2, 256, 0, 6'b00_00_01, 1'b0);

    for (int t = 0; t < 10; t++) begin
      logic [5:0] s;
      logic       sm;
      s  = 6'($urandom);
      sm = 1'($urandom);
      apply_frame(sm ? "R5" : "R4", s, sm);
    end
    summary();
  end
endmodule